// File: doc/BRIEF.md
# Instruction TLB LRU Replacement Tracker

This block keeps the least-recently-used order of a fully associative four-way instruction TLB. The order is stored as pairwise age bits in the top byte of a 32-bit MMU control word, so the tracker never owns that state. It takes the current word in, edits the top byte when one of the ways has been used, and hands the edited word back to the register that holds it. The low 24 bits of the word belong to other MMU controls, and the tracker copies them unchanged.

A way is marked as used by a hit or a refill. The tracker first clears that way's age bits with a fixed AND mask and then sets them with a fixed OR pattern. When the translation logic needs to refill, it raises a replacement request. The tracker then tests the top byte against three match patterns in a fixed priority order and returns the way to be evicted.

Both results are registered by default, one cycle after the inputs. A parameter can remove the register stage. The masks, set patterns and match patterns are also parameters.

Top module: `itlb_lru_tracker`

## Requirements
- R1: While `rst_n` is low, `ctrl_out` is 0 and `victim_idx` is 0.
- R2: `ctrl_out[23:0]` always equals the `ctrl_in[23:0]` presented one clock earlier, whether or not a use was signalled.
- R3: A use of way 0 (`use_idx` = 0) gives `ctrl_out[31:24]` = (`ctrl_in[31:24]` & 0x1F) | 0x00 one cycle later.
- R4: A use of way 1 (`use_idx` = 1) gives `ctrl_out[31:24]` = (`ctrl_in[31:24]` & 0xE7) | 0x80 one cycle later.
- R5: A use of way 2 (`use_idx` = 2) gives `ctrl_out[31:24]` = (`ctrl_in[31:24]` & 0xFB) | 0x50 one cycle later.
- R6: A use of way 3 (`use_idx` = 3) gives `ctrl_out[31:24]` = `ctrl_in[31:24]` | 0x2C one cycle later.
- R7: When `use_vld` is low, `ctrl_out` equals the whole `ctrl_in` of the previous cycle, and `use_idx` has no effect.
- R8: A replacement request selects way 0 one cycle later when `ctrl_in[31:29]` = 3'b111.
- R9: Otherwise, a request selects way 1 when (`ctrl_in` & 0x98000000) = 0x18000000.
- R10: Otherwise, a request selects way 2 when (`ctrl_in` & 0x54000000) = 0x04000000.
- R11: A request that matches none of these three patterns selects way 3.
- R12: When `repl_req` is low, `victim_idx` keeps its previous value.
- R13: When a use and a request arrive in the same cycle, the victim is computed from `ctrl_in` before the update is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_in | input | 32 | Current MMU control word |
| use_vld | input | 1 | A way was hit or refilled this cycle |
| use_idx | input | 2 | The way that was used |
| repl_req | input | 1 | Request a victim way |
| ctrl_out | output | 32 | Control word with the updated age bits |
| victim_idx | output | 2 | The way to evict |

## Verification
The assertions assume the default registered stage and the default patterns. They also assume that `ctrl_in` and the strobes are settled at each rising edge, so every property can relate an output to the inputs of one edge earlier. The stimulus respects this by changing the inputs only on falling edges.

The stimulus covers:
- every way index on all-ones, all-zeros and alternating words;
- the boundary words of each victim pattern, including words that fail by a single bit;
- a chained walk and a random stretch, where idle cycles still carry a nonzero way index.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
   localparam int N_WAYS = 4;
   localparam int WAY_W  = $clog2(N_WAYS);
   localparam int BYTE_W = 8;

   typedef logic [BYTE_W-1:0] age_byte_t;
   typedef logic [WAY_W-1:0]  way_t;

   // Clear then set the age bits belonging to one way.
   function automatic age_byte_t age_touch(input age_byte_t cur,
                                           input age_byte_t clr_keep,
                                           input age_byte_t set_bits);
      return (cur & clr_keep) | set_bits;
   endfunction
endpackage

// File: rtl/itlb_lru_update.sv
module itlb_lru_update
   import itlb_lru_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LRU_LSB = 24,
   parameter logic [N_WAYS-1:0][BYTE_W-1:0] AND_PAT = '0,
   parameter logic [N_WAYS-1:0][BYTE_W-1:0] OR_PAT  = '0
) (
   input  logic [DATA_W-1:0] ctrl_i,
   input  logic              use_i,
   input  way_t              idx_i,
   output logic [DATA_W-1:0] ctrl_o
);
   localparam int TOP_LSB = LRU_LSB + BYTE_W;

   age_byte_t                cur_age;
   age_byte_t [N_WAYS-1:0]   cand;
   age_byte_t                new_age;

   assign cur_age = ctrl_i[TOP_LSB-1:LRU_LSB];

   for (genvar w = 0; w < N_WAYS; w++) begin : g_cand
      assign cand[w] = age_touch(cur_age, AND_PAT[w], OR_PAT[w]);
   end

   assign new_age = use_i ? cand[idx_i] : cur_age;

   if (DATA_W == TOP_LSB) begin : g_top_flush
      assign ctrl_o = {new_age, ctrl_i[LRU_LSB-1:0]};
   end else begin : g_top_pad
      assign ctrl_o = {ctrl_i[DATA_W-1:TOP_LSB], new_age, ctrl_i[LRU_LSB-1:0]};
   end
endmodule

// File: rtl/itlb_lru_victim.sv
module itlb_lru_victim
   import itlb_lru_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LRU_LSB = 24,
   parameter logic [N_WAYS-2:0][BYTE_W-1:0] VIC_MASK = '0,
   parameter logic [N_WAYS-2:0][BYTE_W-1:0] VIC_VAL  = '0
) (
   input  logic [DATA_W-1:0] ctrl_i,
   output way_t              way_o
);
   age_byte_t            age;
   logic [N_WAYS-2:0]    hit;

   assign age = ctrl_i[LRU_LSB+BYTE_W-1:LRU_LSB];

   for (genvar w = 0; w < N_WAYS - 1; w++) begin : g_match
      assign hit[w] = ((age & VIC_MASK[w]) == VIC_VAL[w]);
   end

   // Lowest matching way wins; the last way is the fallback.
   always_comb begin
      way_o = way_t'(N_WAYS - 1);
      for (int w = N_WAYS - 2; w >= 0; w--) begin
         if (hit[w]) way_o = way_t'(w);
      end
   end
endmodule

// File: rtl/itlb_lru_stage.sv
module itlb_lru_stage
   import itlb_lru_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ctrl_d,
   input  way_t              vic_d,
   input  logic              vic_ld,
   output logic [DATA_W-1:0] ctrl_q,
   output way_t              vic_q
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q <= '0;
            vic_q  <= '0;
         end else begin
            ctrl_q <= ctrl_d;
            if (vic_ld) vic_q <= vic_d;
         end
      end
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, vic_ld};
      assign ctrl_q    = ctrl_d;
      assign vic_q     = vic_d;
   end
endmodule

// File: rtl/itlb_lru_tracker.sv
module itlb_lru_tracker
   import itlb_lru_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LRU_LSB = 24,
   parameter bit OUT_REG = 1'b1,
   parameter logic [N_WAYS-1:0][BYTE_W-1:0] AND_PAT  = {8'hFF, 8'hFB, 8'hE7, 8'h1F},
   parameter logic [N_WAYS-1:0][BYTE_W-1:0] OR_PAT   = {8'h2C, 8'h50, 8'h80, 8'h00},
   parameter logic [N_WAYS-2:0][BYTE_W-1:0] VIC_MASK = {8'h54, 8'h98, 8'hE0},
   parameter logic [N_WAYS-2:0][BYTE_W-1:0] VIC_VAL  = {8'h04, 8'h18, 8'hE0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       ctrl_in,
   input  logic              use_vld,
   input  logic [1:0]        use_idx,
   input  logic              repl_req,
   output logic [31:0]       ctrl_out,
   output logic [1:0]        victim_idx
);
   if (DATA_W != 32) begin : g_bad_width
      $error("itlb_lru_tracker: DATA_W must be 32");
   end
   if (LRU_LSB + BYTE_W > DATA_W) begin : g_bad_lsb
      $error("itlb_lru_tracker: age byte exceeds the control word");
   end
   if (WAY_W != 2) begin : g_bad_ways
      $error("itlb_lru_tracker: tracker is built for four ways");
   end

   logic [DATA_W-1:0] ctrl_next;
   way_t              vic_next;

   itlb_lru_update #(
      .DATA_W (DATA_W), .LRU_LSB(LRU_LSB),
      .AND_PAT(AND_PAT), .OR_PAT(OR_PAT)
   ) u_upd (
      .ctrl_i(ctrl_in), .use_i(use_vld), .idx_i(use_idx), .ctrl_o(ctrl_next)
   );

   itlb_lru_victim #(
      .DATA_W  (DATA_W), .LRU_LSB(LRU_LSB),
      .VIC_MASK(VIC_MASK), .VIC_VAL(VIC_VAL)
   ) u_vic (
      .ctrl_i(ctrl_in), .way_o(vic_next)
   );

   itlb_lru_stage #(
      .DATA_W(DATA_W), .OUT_REG(OUT_REG)
   ) u_stg (
      .clk(clk), .rst_n(rst_n),
      .ctrl_d(ctrl_next), .vic_d(vic_next), .vic_ld(repl_req),
      .ctrl_q(ctrl_out), .vic_q(victim_idx)
   );
endmodule

// File: rtl/itlb_lru_chk.sv
// Properties assume the default registered stage and default patterns.
module itlb_lru_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] ctrl_in,
   input logic        use_vld,
   input logic [1:0]  use_idx,
   input logic        repl_req,
   input logic [31:0] ctrl_out,
   input logic [1:0]  victim_idx
);
   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   a_r1_reset_out: assert property (@(posedge clk)
      !rst_n |-> (ctrl_out == 32'h0 && victim_idx == 2'd0));

   a_r2_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> ctrl_out[23:0] == $past(ctrl_in[23:0]));

   a_r7_idle_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(!use_vld)) |-> ctrl_out == $past(ctrl_in));

   a_r3_way0_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(use_vld && use_idx == 2'd0)) |-> ctrl_out[31:29] == 3'b000);

   a_r4_way1_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(use_vld && use_idx == 2'd1)) |-> (ctrl_out[31] && ctrl_out[28:27] == 2'b00));

   a_r6_way3_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(use_vld && use_idx == 2'd3)) |-> (ctrl_out[29] && ctrl_out[27] && ctrl_out[26]));

   a_r8_victim0: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(repl_req && ctrl_in[31:29] == 3'b111)) |-> victim_idx == 2'd0);

   a_r12_victim_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(!repl_req)) |-> $stable(victim_idx));
endmodule

bind itlb_lru_tracker itlb_lru_chk u_chk (.*);

// File: tb/sim_itlb_lru_tracker.sv
`timescale 1ns/1ps
module sim_itlb_lru_tracker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctrl_in = '0;
   logic        use_vld = 1'b0;
   logic [1:0]  use_idx = '0;
   logic        repl_req = 1'b0;
   logic [31:0] ctrl_out;
   logic [1:0]  victim_idx;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] exp_ctrl = '0;
   logic [1:0]  exp_vic  = '0;
   string       pend_tag = "R1";

   always #2.5 clk = ~clk;

   itlb_lru_tracker u0 (
      .clk(clk), .rst_n(rst_n), .ctrl_in(ctrl_in), .use_vld(use_vld),
      .use_idx(use_idx), .repl_req(repl_req), .ctrl_out(ctrl_out),
      .victim_idx(victim_idx)
   );

   function automatic logic [31:0] ref_touch(logic [31:0] w, logic [1:0] i);
      logic [7:0] t = w[31:24];
      case (i)
         2'd0: t = t & 8'h1F;
         2'd1: t = (t & 8'hE7) | 8'h80;
         2'd2: t = (t & 8'hFB) | 8'h50;
         default: t = t | 8'h2C;
      endcase
      return {t, w[23:0]};
   endfunction

   function automatic logic [1:0] ref_victim(logic [31:0] w);
      if (w[31:29] == 3'b111)                    return 2'd0;
      if ((w & 32'h98000000) == 32'h18000000)    return 2'd1;
      if ((w & 32'h54000000) == 32'h04000000)    return 2'd2;
      return 2'd3;
   endfunction

   task automatic compare();
      n_cmp++;
      if (ctrl_out !== exp_ctrl || victim_idx !== exp_vic) begin
         n_bad++;
         $display("FAIL %s: ctrl_out=%h victim=%0d expected ctrl_out=%h victim=%0d",
                  pend_tag, ctrl_out, victim_idx, exp_ctrl, exp_vic);
      end
   endtask

   // Compare the previous step's result, then apply a new stimulus.
   task automatic step(string tag, logic [31:0] w, logic uv, logic [1:0] ui, logic rq);
      @(negedge clk);
      compare();
      ctrl_in  = w;
      use_vld  = uv;
      use_idx  = ui;
      repl_req = rq;
      exp_ctrl = uv ? ref_touch(w, ui) : w;
      if (rq) exp_vic = ref_victim(w);
      pend_tag = tag;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      pend_tag = "R1";
      compare();
      rst_n    = 1'b1;
      exp_ctrl = '0;
      exp_vic  = '0;
      pend_tag = "R7";

      // Way updates on several words (R2 low bits checked in each)
      step("R3", 32'hFFFF_FFFF, 1, 2'd0, 0);
      step("R4", 32'hFFFF_FFFF, 1, 2'd1, 0);
      step("R5", 32'hFFFF_FFFF, 1, 2'd2, 0);
      step("R6", 32'h0000_0000, 1, 2'd3, 0);
      step("R4", 32'h0012_3456, 1, 2'd1, 0);
      step("R5", 32'h0000_0000, 1, 2'd2, 0);
      step("R3", 32'hA5A5_A5A5, 1, 2'd0, 0);
      step("R6", 32'h5A5A_5A5A, 1, 2'd3, 0);
      step("R2", 32'h3C00_BEEF, 1, 2'd2, 0);
      // Idle cycles with a live index
      step("R7", 32'hDEAD_BEEF, 0, 2'd3, 0);
      step("R7", 32'h1234_5678, 0, 2'd1, 0);
      // Victim patterns
      step("R8",  32'hE000_0000, 0, 2'd0, 1);
      step("R8",  32'hFFFF_FFFF, 0, 2'd0, 1);
      step("R9",  32'h1800_0000, 0, 2'd0, 1);
      step("R9",  32'h7B00_0000, 0, 2'd0, 1);
      step("R10", 32'h0400_0000, 0, 2'd0, 1);
      step("R10", 32'h8700_0000, 0, 2'd0, 1);
      step("R11", 32'h0000_0000, 0, 2'd0, 1);
      step("R11", 32'h9800_0000, 0, 2'd0, 1);
      step("R11", 32'hC000_0000, 0, 2'd0, 1);
      // Hold with no request
      step("R12", 32'hE000_0000, 0, 2'd0, 0);
      step("R12", 32'h1800_0000, 1, 2'd2, 0);
      // Use and request together: victim from the word before update
      step("R13", 32'hE000_0000, 1, 2'd0, 1);
      step("R13", 32'h0400_0000, 1, 2'd3, 1);
      // Chained walk through all ways
      for (int k = 0; k < 16; k++) begin
         step("R6", exp_ctrl, 1, 2'(k), 1);
      end
      // Random stretch
      for (int k = 0; k < 300; k++) begin
         step("R2", $urandom, 1'($urandom), 2'($urandom), 1'($urandom));
      end
      step("R7", 32'h0, 0, 2'd0, 0);
      @(negedge clk);
      compare();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule